// File: doc/BRIEF.md
# Frame Buffer Fetch Address Sequencer

This block produces the memory addresses a display controller uses to stream a frame buffer out of external memory, one 16-byte quadword per fetch. Software loads a start address into a base register. The block copies that base into a running pointer, and each acknowledged fetch moves the pointer forward by one quadword. When the pointer reaches the end of the frame, the block goes back to the base and starts the next frame.

The base is copied into the running pointer on two occasions: when the display is switched on, and whenever a frame completes. The block latches the end address at each copy. Software can therefore write a new base in the middle of a frame, and the new base takes effect at the next frame boundary, which gives double-buffered frame switching. A sticky status flag records each copy and can raise an interrupt. Software may write a new base while the display is off, or right after that interrupt fires.

Registers, selected by a 2-bit offset:
- Offset 0 holds the base. It is read/write.
- Offset 1 holds the running pointer. It is read-only.
- Offset 2 holds the reload status in bit 0. Writing 1 clears it.
- Offset 3 holds the interrupt enable in bit 0.

Top module: `fb_addr_seq`

## Requirements
- R1: After a synchronous reset, the following all read 0: the base register (offset 0), the status bit (offset 2, bit 0), the interrupt enable (offset 3, bit 0), `irq` and `fetch_req`.
- R2: A write to offset 0 stores the write data with bits 3..0 forced to zero. A later read of offset 0 returns the stored value.
- R3: On the clock edge where `disp_en` is sampled 1 after being sampled 0, the running pointer (shown on `fetch_addr`) takes the base value and the status bit is set.
- R4: Each cycle with `fetch_req` and `fetch_ack` both high moves `fetch_addr` forward by 16. Without an acknowledge, `fetch_addr` holds its value.
- R5: If an advance would make the pointer equal the latched end address, the pointer instead takes the current base and the status bit is set.
- R6: The end address is latched as base plus `frame_bytes` (bits 3..0 ignored) at every reload. A base write or a `frame_bytes` change made during a frame does not alter the frame in progress; the new values apply from the next reload.
- R7: Lowering `disp_en` drops `fetch_req` in the same cycle, before any clock edge. The pointer then freezes and ignores `fetch_ack`, and the base is left unchanged. Raising `disp_en` again reloads from the base.
- R8: Writing offset 2 with bit 0 set clears the status bit. Writing it with bit 0 clear leaves the status bit unchanged.
- R9: `irq` equals the status bit ANDed with the interrupt enable bit.
- R10: A write to offset 1 has no effect. The running pointer read back there matches `fetch_addr`.
- R11: `fetch_req` stays low for as long as `disp_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset sampled at the previous edge |
| disp_en | input | 1 | Display enable |
| frame_bytes | input | 24 | Frame size in bytes, a nonzero multiple of 16 |
| fetch_req | output | 1 | Fetch request |
| fetch_ack | input | 1 | Fetch acknowledge from the memory side |
| fetch_addr | output | 32 | Address of the quadword to fetch |
| irq | output | 1 | Reload interrupt |

## Verification
Pointer loads, advances, reloads, status changes and register writes all appear on the ports right after the edge that samples the stimulus. Because `reg_rdata` is a register, a read returns its value one edge after the offset is presented. The bench therefore drives inputs on the falling edge and samples 1 ns after the next rising edge. The one exception is `fetch_req` dropping on disable, which is combinational. The bench samples it 1 ns after lowering `disp_en`, before any rising edge. The bench never reads the running pointer before the first enable edge has loaded it.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;
  localparam int QW_BYTES = 16;
  localparam int QW_LSB   = 4;
  localparam int REG_AW   = 2;

  localparam logic [REG_AW-1:0] OFS_BASE = 2'd0;
  localparam logic [REG_AW-1:0] OFS_CUR  = 2'd1;
  localparam logic [REG_AW-1:0] OFS_STAT = 2'd2;
  localparam logic [REG_AW-1:0] OFS_MASK = 2'd3;
endpackage

// File: rtl/fbseq_fetch.sv
module fbseq_fetch (
  input  logic clk,
  input  logic rst,
  input  logic disp_en,
  input  logic fetch_ack,
  output logic load_start,
  output logic fetch_req,
  output logic step
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= disp_en;
  end

  // Enable edge and request gating
  assign load_start = disp_en & ~en_q;
  assign fetch_req  = disp_en & en_q;
  assign step       = fetch_req & fetch_ack;

  // R7: no advance may follow a cycle where the display was off
  a_r7_no_step_after_off: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> !step);
endmodule

// File: rtl/fbseq_ptr.sv
module fbseq_ptr
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] frame_bytes,
  output logic [ADDR_W-1:0] cur,
  output logic              reload
);
  localparam logic [ADDR_W-1:0] ALIGN = {{(ADDR_W-QW_LSB){1'b1}}, {QW_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(QW_BYTES);

  logic [ADDR_W-1:0] cur_q, end_q, nxt, size_ext;
  logic              wrap, loaded_q;

  assign size_ext = ADDR_W'(frame_bytes) & ALIGN;
  assign nxt      = cur_q + STEP;
  assign wrap     = step && (nxt == end_q);
  assign reload   = load_start | wrap;
  assign cur      = cur_q;

  // Pointer and end address carry no reset value
  always_ff @(posedge clk) begin
    if (reload) begin
      cur_q <= base;
      end_q <= base + size_ext;
    end else if (step) begin
      cur_q <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             loaded_q <= 1'b0;
    else if (load_start) loaded_q <= 1'b1;
  end

  // R3: enable edge copies base
  a_r3_load_copies_base: assert property (@(posedge clk) disable iff (rst)
    load_start |=> (cur_q == $past(base)));
  // R4: acknowledged fetch moves by one quadword
  a_r4_step_one_qw: assert property (@(posedge clk) disable iff (rst || !loaded_q)
    (step && !wrap) |=> (cur_q == $past(cur_q) + STEP));
  // R7: pointer frozen without step or reload
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst || !loaded_q)
    (!step && !load_start) |=> $stable(cur_q));
  // R6: end address changes only at reload
  a_r6_end_latched: assert property (@(posedge clk) disable iff (rst || !loaded_q)
    !reload |=> $stable(end_q));
endmodule

// File: rtl/fbseq_regs.sv
module fbseq_regs
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              reload,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              status,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] ALIGN = {{(ADDR_W-QW_LSB){1'b1}}, {QW_LSB{1'b0}}};

  logic [ADDR_W-1:0] base_q, rdata_q;
  logic              stat_q, mask_q;
  logic              wr_base, wr_stat, wr_mask;

  assign wr_base = reg_wr && (reg_addr == OFS_BASE);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_mask = reg_wr && (reg_addr == OFS_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      stat_q  <= 1'b0;
      mask_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_base) base_q <= reg_wdata & ALIGN;
      if (wr_mask) mask_q <= reg_wdata[0];
      if (reload)                      stat_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) stat_q <= 1'b0;
      case (reg_addr)
        OFS_BASE: rdata_q <= base_q;
        OFS_CUR:  rdata_q <= cur;
        OFS_STAT: rdata_q <= ADDR_W'(stat_q);
        default:  rdata_q <= ADDR_W'(mask_q);
      endcase
    end
  end

  assign base      = base_q;
  assign reg_rdata = rdata_q;
  assign status    = stat_q;
  assign irq       = stat_q & mask_q;

  // R8: write-one clears when no reload competes
  a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[0] && !reload) |=> !stat_q);
  // R8: write of zero keeps a set flag
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (stat_q && wr_stat && !reg_wdata[0]) |=> stat_q);
endmodule

// File: rtl/fb_addr_seq.sv
module fb_addr_seq
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              disp_en,
  input  logic [SIZE_W-1:0] frame_bytes,
  output logic              fetch_req,
  input  logic              fetch_ack,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              irq
);
  logic              load_start, step, reload, status;
  logic [ADDR_W-1:0] base, cur;

  fbseq_fetch u_fetch (
    .clk        (clk),
    .rst        (rst),
    .disp_en    (disp_en),
    .fetch_ack  (fetch_ack),
    .load_start (load_start),
    .fetch_req  (fetch_req),
    .step       (step)
  );

  fbseq_ptr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .load_start  (load_start),
    .step        (step),
    .base        (base),
    .frame_bytes (frame_bytes),
    .cur         (cur),
    .reload      (reload)
  );

  fbseq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reload    (reload),
    .cur       (cur),
    .base      (base),
    .reg_rdata (reg_rdata),
    .status    (status),
    .irq       (irq)
  );

  assign fetch_addr = cur;

  // R5: every reload leaves the status flag set
  a_r5_reload_flags: assert property (@(posedge clk) disable iff (rst)
    reload |=> status);
  // R11: a disabled display sees no request at the next edge either
  a_r11_quiet_off: assert property (@(posedge clk) disable iff (rst)
    (!disp_en && !$past(disp_en)) |-> !fetch_req);
endmodule

// File: tb/tb_fb_addr_seq.sv
module tb_fb_addr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        disp_en = 1'b0;
  logic [23:0] frame_bytes = '0;
  logic        fetch_req;
  logic        fetch_ack = 1'b0;
  logic [31:0] fetch_addr;
  logic        irq;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic [31:0] rv;

  localparam logic [31:0] W_VEC [8] = '{32'h0000_0000, 32'h0000_000F, 32'h1234_5678,
    32'hFFFF_FFFF, 32'h8000_0010, 32'h0000_1007, 32'hABCD_EF19, 32'h0000_2000};
  localparam logic [31:0] E_VEC [8] = '{32'h0000_0000, 32'h0000_0000, 32'h1234_5670,
    32'hFFFF_FFF0, 32'h8000_0010, 32'h0000_1000, 32'hABCD_EF10, 32'h0000_2000};

  fb_addr_seq dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_en(disp_en),
    .frame_bytes(frame_bytes), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic ack1();
    @(negedge clk);
    fetch_ack = 1'b1;
    @(posedge clk); #1;
    fetch_ack = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    disp_en = v;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    // R1 reset state
    check("R1 fetch_req", 32'(fetch_req), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(2'd0, rv); check("R1 base", rv, 32'h0);
    rd(2'd2, rv); check("R1 status", rv, 32'h0);
    rd(2'd3, rv); check("R1 mask", rv, 32'h0);

    // R2 table walk: write base, read back aligned value
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, W_VEC[i]);
      rd(2'd0, rv);
      check("R2 base align", rv, E_VEC[i]);
    end

    // R3 enable edge loads base
    wr(2'd0, 32'h0000_1000);
    wr(2'd3, 32'h1);
    frame_bytes = 24'h40;
    set_en(1'b1);
    check("R3 load addr", fetch_addr, 32'h0000_1000);
    check("R3 req", 32'(fetch_req), 32'h1);
    check("R9 irq with mask", 32'(irq), 32'h1);
    rd(2'd2, rv); check("R3 status set", rv, 32'h1);

    // R8 clear
    wr(2'd2, 32'h1);
    check("R9 irq after clear", 32'(irq), 32'h0);
    rd(2'd2, rv); check("R8 cleared", rv, 32'h0);

    // R4 hold and step
    repeat (3) @(posedge clk);
    #1 check("R4 hold", fetch_addr, 32'h0000_1000);
    ack1(); check("R4 step1", fetch_addr, 32'h0000_1010);
    ack1(); ack1(); check("R4 step3", fetch_addr, 32'h0000_1030);

    // R6 base write mid-frame; R10 current is read-only
    wr(2'd0, 32'h0000_2000);
    check("R6 frame untouched", fetch_addr, 32'h0000_1030);
    wr(2'd1, 32'h000D_EAD0);
    rd(2'd1, rv); check("R10 cur read-only", rv, 32'h0000_1030);

    // R5 end of frame reload
    ack1();
    check("R5 reload to base", fetch_addr, 32'h0000_2000);
    check("R5 irq on reload", 32'(irq), 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, rv); check("R8 zero write keeps", rv, 32'h1);
    wr(2'd2, 32'h1);

    // R6 size change mid-frame only applies next frame
    frame_bytes = 24'h2F;
    ack1(); ack1(); ack1();
    check("R6 old size kept", fetch_addr, 32'h0000_2030);
    ack1(); check("R6 wrap old size", fetch_addr, 32'h0000_2000);
    ack1(); check("R6 new size step", fetch_addr, 32'h0000_2010);
    ack1(); check("R6 new size wrap", fetch_addr, 32'h0000_2000);
    ack1();

    // R7 disable: request drops at once, pointer freezes
    @(negedge clk);
    disp_en = 1'b0; fetch_ack = 1'b1;
    #1 check("R7 req drops", 32'(fetch_req), 32'h0);
    repeat (3) @(posedge clk);
    #1 check("R11 req low", 32'(fetch_req), 32'h0);
    fetch_ack = 1'b0;
    check("R7 frozen", fetch_addr, 32'h0000_2010);
    rd(2'd1, rv); check("R7 cur read", rv, 32'h0000_2010);
    rd(2'd0, rv); check("R7 base kept", rv, 32'h0000_2000);

    // R7 re-enable with mask off, R9
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0000_3000);
    set_en(1'b1);
    check("R7 reload on re-enable", fetch_addr, 32'h0000_3000);
    check("R9 masked irq", 32'(irq), 32'h0);
    wr(2'd3, 32'h1);
    check("R9 unmasked irq", 32'(irq), 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule